// File: doc/BRIEF.md
# Dual-Timebase Capture/Compare Channel Array

This block holds a bank of 16-bit channel registers. Each channel has one pin (an input sample plus an output value and an output enable) and one interrupt pulse. Two free-running 16-bit up-counters serve as the time bases. Each counter reloads from its own reload register when it passes 0xFFFF. Each counter advances on one of three enables: a divided system clock, an overflow pulse from outside, or rising edges on an external count pin. The count pin is available to timer 0 only.

Each channel picks one of the two counters. It then works in one of two ways. As a capture channel it stores the counter on a chosen pin edge. As a compare channel it watches for its value to appear on the counter, and then pulses its interrupt and/or drives its pin. A single-event flag limits a compare channel to one event. A pair flag lets a channel in the upper half of the bank toggle the pin of its partner in the lower half. Software configures and reads everything through a write port and a combinational read port that share one 6-bit address space.

Top module: `ccarray`

## Requirements
- R1: After reset every channel value, channel setting and timer register reads 0, and `cc_out`, `cc_oe`, `cc_irq` and `tmr_irq` are low. The address map is: channel value at 0x00+i; channel setting at 0x10+i; for timer t, the count at 0x20+4t, the reload at 0x21+4t and the control at 0x22+4t.
- R2: A running timer advances by one on each enable. An enable while the count is 0xFFFF loads the reload value instead, and `tmr_irq[t]` pulses for one cycle in the following cycle.
- R3: Timer control bit 0 is run, bits 2:1 pick the source and bits 6:3 hold k. Source 0 gives one enable every 2^k cycles, and the first enable falls one cycle after the control write. Source 1 gives one enable per clock with `ext_ovf` high. Source 2 gives one enable per rising edge of `ext_cnt` on timer 0 and no enables on timer 1.
- R4: A channel setting is packed as bit 0 = timer select, bits 3:1 = mode, bit 4 = single event, bit 5 = pair. The setting read-back adds bit 6 = spent. Modes 1, 2 and 3 capture on a rising edge, a falling edge or either edge of the pin. The stored value is the selected counter two clocks after the first clock edge that samples the new pin level, and `cc_irq` pulses once per capture.
- R5: In mode 4, each time the selected counter steps onto the channel value, `cc_irq` pulses once, one cycle after the counter update.
- R6: In mode 5 the pin output toggles on every such match and raises the interrupt. `cc_oe` is high in modes 5 and 7 only.
- R7: In mode 6 only the first match after an overflow of the selected counter (or after a setting write) raises the interrupt. A later match in the same period, after software rewinds the counter, raises nothing.
- R8: In mode 7 the first match in a period drives the pin to 1. An overflow of the selected counter drives it to 0. When a match on the reload value coincides with the overflow, the pin ends at 1.
- R9: A lower-half channel i in mode 5 with the pair bit set also toggles its pin on each compare event of channel i+NCH/2. Two events in the same cycle cancel.
- R10: With the single-event bit set, the first compare event sets spent, and no further compare event occurs until the setting is rewritten. An overflow clear in mode 7 still applies, so mode 7 gives one pulse.
- R11: A compare channel follows only its selected counter. A channel on a stopped counter produces no events while the other counter runs.
- R12: A channel in mode 0 never pulses its interrupt and never drives its pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | W | Read data (combinational) |
| ext_ovf | input | 1 | External overflow pulse used as a timer enable |
| ext_cnt | input | 1 | External count pin for timer 0 |
| cc_in | input | NCH | Channel pin samples |
| cc_out | output | NCH | Channel pin output values |
| cc_oe | output | NCH | Channel pin output enables |
| cc_irq | output | NCH | Channel interrupt pulses |
| tmr_irq | output | 2 | Timer overflow pulses |

## Verification
The hardest state to reach is the interplay at a period boundary. There a once-per-period lockout must re-arm, a set/clear pin must both clear and set in the same cycle, and a single-event channel must stay spent over several wraps. The bench sets the reload to 0xFFF8, so each period is only eight counts. It then replays trials of growing length that each cross several overflows. After every trial it compares each channel's interrupt count, pin level and spent flag against a count-by-count model. A separate sequence rewinds the counter within a period to show the once-per-period lockout.

// File: rtl/ccarray.sv
module ccarray #(
  parameter int NCH = 16,
  parameter int W   = 16,
  parameter int PSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [5:0]     wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic [5:0]     rd_addr,
  output logic [W-1:0]   rd_data,
  input  logic           ext_ovf,
  input  logic           ext_cnt,
  input  logic [NCH-1:0] cc_in,
  output logic [NCH-1:0] cc_out,
  output logic [NCH-1:0] cc_oe,
  output logic [NCH-1:0] cc_irq,
  output logic [1:0]     tmr_irq
);
  localparam int CW = $clog2(NCH);
  localparam int HALF = NCH / 2;
  localparam logic [5:0] CFG_BASE = 6'h10;
  localparam logic [5:0] TMR_BASE = 6'h20;
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0]   cnt [2];
  logic [W-1:0]   rel [2];
  logic [6:0]     tctl [2];
  logic [PSW-1:0] pre [2];
  logic [1:0]     tick, tnew, ovf, cwr;
  logic [2:0]     xs;
  logic           xrise;

  logic [W-1:0]   ccv [NCH];
  logic [5:0]     cfg [NCH];
  logic [2:0]     md [NCH];
  logic [NCH-1:0] sel, s1, s2, s3, done, spent;
  logic [NCH-1:0] match, ev, cap, ptog, vwr, fwr;

  assign xrise   = xs[1] & ~xs[2];
  assign tmr_irq = ovf;

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      cwr[t]  = wr_en && wr_addr == TMR_BASE + 6'(4 * t);
      tick[t] = tctl[t][0] && (
                  (tctl[t][2:1] == 2'd0 &&
                   (pre[t] & ((PSW'(1) << tctl[t][6:3]) - PSW'(1))) == '0) ||
                  (tctl[t][2:1] == 2'd1 && ext_ovf) ||
                  (tctl[t][2:1] == 2'd2 && t == 0 && xrise));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs <= '0;
      tnew <= '0;
      ovf <= '0;
      for (int t = 0; t < 2; t++) begin
        cnt[t] <= '0;
        rel[t] <= '0;
        tctl[t] <= '0;
        pre[t] <= '0;
      end
    end else begin
      xs <= {xs[1:0], ext_cnt};
      for (int t = 0; t < 2; t++) begin
        pre[t] <= (wr_en && wr_addr == TMR_BASE + 6'(4 * t + 2)) ? '0 : pre[t] + PSW'(1);
        if (wr_en && wr_addr == TMR_BASE + 6'(4 * t + 1)) rel[t] <= wr_data;
        if (wr_en && wr_addr == TMR_BASE + 6'(4 * t + 2)) tctl[t] <= wr_data[6:0];
        tnew[t] <= tick[t] && !cwr[t];
        ovf[t]  <= tick[t] && !cwr[t] && cnt[t] == TOP;
        if (cwr[t]) cnt[t] <= wr_data;
        else if (tick[t]) cnt[t] <= (cnt[t] == TOP) ? rel[t] : cnt[t] + W'(1);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      md[i]    = cfg[i][3:1];
      sel[i]   = cfg[i][0];
      vwr[i]   = wr_en && wr_addr == 6'(i);
      fwr[i]   = wr_en && wr_addr == CFG_BASE + 6'(i);
      match[i] = md[i][2] && tnew[sel[i]] && cnt[sel[i]] == ccv[i];
      ev[i]    = match[i] && !spent[i] && !(md[i][1] && done[i] && !ovf[sel[i]]);
      cap[i]   = (md[i] == 3'd1 && s2[i] && !s3[i]) ||
                 (md[i] == 3'd2 && !s2[i] && s3[i]) ||
                 (md[i] == 3'd3 && (s2[i] ^ s3[i]));
      cc_oe[i] = md[i] == 3'd5 || md[i] == 3'd7;
    end
    for (int i = 0; i < NCH; i++)
      ptog[i] = (i < HALF) && cfg[i][5] && md[i] == 3'd5 && ev[(i + HALF) % NCH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      done <= '0; spent <= '0;
      cc_out <= '0; cc_irq <= '0;
      for (int i = 0; i < NCH; i++) begin
        ccv[i] <= '0;
        cfg[i] <= '0;
      end
    end else begin
      s1 <= cc_in; s2 <= s1; s3 <= s2;
      for (int i = 0; i < NCH; i++) begin
        if (vwr[i]) ccv[i] <= wr_data;
        else if (cap[i]) ccv[i] <= cnt[sel[i]];
        cc_irq[i] <= cap[i] | ev[i];
        if (fwr[i]) begin
          cfg[i] <= wr_data[5:0];
          done[i] <= 1'b0;
          spent[i] <= 1'b0;
        end else if (ev[i]) begin
          done[i] <= 1'b1;
          if (cfg[i][4]) spent[i] <= 1'b1;
        end else if (ovf[sel[i]]) begin
          done[i] <= 1'b0;
        end
        if (md[i] == 3'd5) cc_out[i] <= cc_out[i] ^ (ev[i] ^ ptog[i]);
        else if (md[i] == 3'd7) begin
          if (ev[i]) cc_out[i] <= 1'b1;
          else if (ovf[sel[i]]) cc_out[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[5:4] == 2'b00 && 32'(rd_addr[3:0]) < NCH)
      rd_data = ccv[rd_addr[CW-1:0]];
    else if (rd_addr[5:4] == 2'b01 && 32'(rd_addr[3:0]) < NCH)
      rd_data = W'({spent[rd_addr[CW-1:0]], cfg[rd_addr[CW-1:0]]});
    for (int t = 0; t < 2; t++) begin
      if (rd_addr == TMR_BASE + 6'(4 * t))     rd_data = cnt[t];
      if (rd_addr == TMR_BASE + 6'(4 * t + 1)) rd_data = rel[t];
      if (rd_addr == TMR_BASE + 6'(4 * t + 2)) rd_data = W'(tctl[t]);
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_tchk
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick[t] && !cwr[t] && cnt[t] == TOP |=> tmr_irq[t] && cnt[t] == $past(rel[t]));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cchk
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cap[i] && !vwr[i] |=> ccv[i] == $past(cnt[sel[i]]));
    p_irq_every_r5: assert property (@(posedge clk) disable iff (!rst_n)
      md[i] == 3'd4 && match[i] && !spent[i] |=> cc_irq[i]);
    p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      md[i] == 3'd5 && ev[i] && !ptog[i] |=> cc_out[i] != $past(cc_out[i]));
    p_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      md[i] == 3'd6 && done[i] && !ovf[sel[i]] |=> !cc_irq[i]);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      md[i] == 3'd7 && ovf[sel[i]] && !ev[i] |=> !cc_out[i]);
    p_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ptog[i] && !ev[i] |=> cc_out[i] != $past(cc_out[i]));
    p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      spent[i] && !fwr[i] && md[i] == 3'd5 && !ptog[i] |=> $stable(cc_out[i]));
  end
endmodule

// File: tb/test_ccarray.sv
module test_ccarray;
  localparam int NCH = 16;
  logic clk = 0, rst_n = 0, wr_en = 0, ext_ovf = 0, ext_cnt = 0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [NCH-1:0] cc_in = '0, cc_out, cc_oe, cc_irq;
  logic [1:0] tmr_irq;
  int tests = 0, fails = 0;
  int icnt [NCH] = '{default: 0};
  int tcnt [2] = '{default: 0};
  int snap [NCH];
  int mcfg [NCH], mcc [NCH], mpin [NCH], mdone [NCH], mspent [NCH], mirq [NCH], hit [NCH];
  int d, v, pv, ov, md, tg, ts, n;

  always #2 clk = ~clk;

  ccarray i_ccarray (.*);

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) if (cc_irq[i]) icnt[i]++;
    for (int t = 0; t < 2; t++) if (tmr_irq[t]) tcnt[t]++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int dt);
    wr_addr = 6'(a); wr_data = 16'(dt); wr_en = 1;
    @(posedge clk); @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int dt);
    rd_addr = 6'(a); #1; dt = int'(rd_data);
  endtask

  task automatic run(input int t, input int ctl, input int cyc);
    wr(32 + 4 * t + 2, ctl | 1);
    repeat (cyc - 1) @(negedge clk);
    wr(32 + 4 * t + 2, ctl);
  endtask

  function automatic int nxt(input int x, input int r);
    return (x == 'hFFFF) ? r : x + 1;
  endfunction

  function automatic string tagof(input int ch);
    case (ch)
      0: return "R9"; 1: return "R6"; 2, 6: return "R7"; 3, 7: return "R8";
      4, 12: return "R10"; 5: return "R11"; 8: return "R5"; default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 32; a++) begin rd(a, d); chk("R1 reg", d, 0); end
    for (int a = 32; a < 39; a++) if (a != 35) begin rd(a, d); chk("R1 timer", d, 0); end
    chk("R1 out", int'(cc_out), 0); chk("R1 oe", int'(cc_oe), 0);
    chk("R1 irq", int'(cc_irq), 0); chk("R1 tirq", int'(tmr_irq), 0);

    // R2 wrap and reload
    wr(33, 'hFFF0); wr(32, 'hFFFA); ts = tcnt[0];
    run(0, 0, 10); repeat (3) @(negedge clk);
    v = 'hFFFA; for (int s = 0; s < 10; s++) v = nxt(v, 'hFFF0);
    rd(32, d); chk("R2 count", d, v); chk("R2 tirq", tcnt[0] - ts, 1);

    // R3 prescaler sweep
    for (int k = 1; k < 4; k++)
      for (int j = 0; j < 3; j++) begin
        n = 5 + 6 * j;
        wr(32, 0); run(0, k << 3, n); repeat (2) @(negedge clk);
        rd(32, d); chk("R3 prescale", d, (n + (1 << k) - 1) >> k);
      end

    // R3 external overflow pulses
    wr(32, 0); wr(34, (1 << 1) | 1);
    for (int p = 0; p < 5; p++) begin
      ext_ovf = 1; @(negedge clk); ext_ovf = 0; repeat (2) @(negedge clk);
    end
    wr(34, 0); rd(32, d); chk("R3 ext ovf", d, 5);

    // R3 external count pin, timer 0 only
    wr(32, 0); wr(36, 0); wr(34, (2 << 1) | 1); wr(38, (2 << 1) | 1);
    for (int p = 0; p < 4; p++) begin
      ext_cnt = 1; repeat (3) @(negedge clk); ext_cnt = 0; repeat (3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    wr(34, 0); wr(38, 0);
    rd(32, d); chk("R3 ext cnt t0", d, 4);
    rd(36, d); chk("R3 ext cnt t1", d, 0);

    // Compare sweep over mode mix, reload 0xFFF8
    for (int c = 0; c < NCH; c++) begin mcfg[c] = 0; mcc[c] = 0; mpin[c] = 0; end
    mcfg[0] = 'h2A; mcc[0] = 'hFFF9;  mcfg[1] = 'h0A; mcc[1] = 'hFFFC;
    mcfg[2] = 'h0C; mcc[2] = 'hFFFD;  mcfg[3] = 'h0E; mcc[3] = 'hFFFE;
    mcfg[4] = 'h1A; mcc[4] = 'hFFF9;  mcfg[5] = 'h09; mcc[5] = 'hFFFA;
    mcfg[6] = 'h0C; mcc[6] = 'hFFF8;  mcfg[7] = 'h0E; mcc[7] = 'hFFF8;
    mcfg[8] = 'h08; mcc[8] = 'hFFFB;  mcfg[12] = 'h1E; mcc[12] = 'hFFFD;
    wr(36, 0); wr(33, 'hFFF8);
    for (int c = 0; c < NCH; c++) wr(c, mcc[c]);
    for (int tr = 0; tr < 4; tr++) begin
      n = 4 + 9 * tr;
      wr(32, 'hFFF8); v = 'hFFF8;
      for (int c = 0; c < NCH; c++) begin
        wr(16 + c, mcfg[c]); mdone[c] = 0; mspent[c] = 0; mirq[c] = 0; snap[c] = icnt[c];
      end
      run(0, 0, n); repeat (4) @(negedge clk);
      for (int s = 0; s < n; s++) begin
        pv = v; v = nxt(v, 'hFFF8); ov = (pv == 'hFFFF);
        for (int c = 0; c < NCH; c++) begin
          md = (mcfg[c] >> 1) & 7; hit[c] = 0;
          if ((mcfg[c] & 1) == 0) begin
            if (ov != 0) begin mdone[c] = 0; if (md == 7) mpin[c] = 0; end
            hit[c] = int'(md >= 4 && v == mcc[c] && mspent[c] == 0 && !(md >= 6 && mdone[c] != 0));
          end
        end
        for (int c = 0; c < NCH; c++) begin
          md = (mcfg[c] >> 1) & 7;
          if (hit[c] != 0) begin
            mirq[c]++; mdone[c] = 1;
            if ((mcfg[c] & 16) != 0) mspent[c] = 1;
            if (md == 7) mpin[c] = 1;
          end
          if (md == 5) begin
            tg = hit[c] ^ int'((mcfg[c] & 32) != 0 && c < NCH / 2 && hit[(c + NCH / 2) % NCH] != 0);
            mpin[c] ^= tg;
          end
        end
      end
      for (int c = 0; c < NCH; c++) begin
        md = (mcfg[c] >> 1) & 7;
        chk({tagof(c), " irq"}, icnt[c] - snap[c], mirq[c]);
        chk({tagof(c), " pin"}, int'(cc_out[c]), mpin[c]);
        chk({tagof(c), " oe"}, int'(cc_oe[c]), int'(md == 5 || md == 7));
        rd(16 + c, d); chk({tagof(c), " spent"}, (d >> 6) & 1, mspent[c]);
      end
    end

    // R7 once per period against R5 every match, with rewind
    for (int c = 0; c < NCH; c++) wr(16 + c, 0);
    wr(0, 5); wr(2, 5); wr(16, 'h08); wr(18, 'h0C); wr(33, 0); wr(32, 0);
    snap[0] = icnt[0]; snap[2] = icnt[2];
    run(0, 0, 8); repeat (3) @(negedge clk);
    wr(32, 2); run(0, 0, 8); repeat (3) @(negedge clk);
    chk("R5 rewind", icnt[0] - snap[0], 2);
    chk("R7 rewind", icnt[2] - snap[2], 1);
    wr(32, 'hFFFE); run(0, 0, 8); repeat (3) @(negedge clk);
    chk("R5 rearm", icnt[0] - snap[0], 3);
    chk("R7 rearm", icnt[2] - snap[2], 2);

    // R4 capture edges
    wr(16, 0); wr(18, 0);
    wr(9, 0); wr(10, 0); wr(11, 0);
    wr(25, 'h02); wr(26, 'h04); wr(27, 'h07);
    wr(32, 'h1111); wr(36, 'h2222);
    for (int c = 9; c < 12; c++) snap[c] = icnt[c];
    cc_in[11:9] = 3'b111; repeat (4) @(negedge clk);
    rd(9, d);  chk("R4 rise", d, 'h1111);
    rd(10, d); chk("R4 fall ignores rise", d, 0);
    rd(11, d); chk("R4 both t1", d, 'h2222);
    chk("R4 irq rise", icnt[9] - snap[9], 1);
    chk("R4 irq fall", icnt[10] - snap[10], 0);
    chk("R4 irq both", icnt[11] - snap[11], 1);
    wr(32, 'h3333); wr(36, 'h4444);
    cc_in[11:9] = 3'b000; repeat (4) @(negedge clk);
    rd(9, d);  chk("R4 rise ignores fall", d, 'h1111);
    rd(10, d); chk("R4 fall", d, 'h3333);
    rd(11, d); chk("R4 both fall", d, 'h4444);
    chk("R4 irq both twice", icnt[11] - snap[11], 2);
    wr(32, 'h0100); wr(34, 1);
    cc_in[9] = 1'b1; repeat (6) @(negedge clk);
    wr(34, 0);
    rd(9, d); chk("R4 latency", d, 'h0102);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule